// File: doc/BRIEF.md
# Dual-Channel Audio Noise Gate

This block gates two streams of 24-bit signed PCM samples that share a sample-valid strobe. For each channel it compares the magnitude of every valid sample with a threshold chosen from a small table of linear levels. When a channel has stayed quiet for a programmed number of time-base ticks, the block sets that channel's mute flag and forces its output samples to zero. The first loud sample clears the mute at once, and that same sample passes through unchanged. Muting is abrupt, with no ramp.

A two-address write port sets the controls. There is a gate enable for each channel, plus a gang mode in which one shared enable replaces both per-channel enables. The port also sets a 3-bit threshold code, a boost bit that raises the whole threshold table by 30 dB, and a 2-bit delay code. An external clock-enable `tick` with a 1 ms period supplies the time base. Each channel runs its own state machine with three states:

- `ST_IDLE`: the gate is off, the channel is unmuted and the counter is clear.
- `ST_ARMED`: the gate is on, the channel is unmuted and quiet ticks are being counted.
- `ST_MUTED`: the gate is on and the output is forced to zero.

The transitions are:

- *arm*: `ST_IDLE` → `ST_ARMED`, when the gate becomes enabled.
- *retrigger*: `ST_ARMED` → `ST_ARMED` with the counter cleared, on a loud sample.
- *attack*: `ST_ARMED` → `ST_MUTED`, on the tick that completes the delay.
- *release*: `ST_MUTED` → `ST_ARMED`, on a loud sample.
- *disarm*: `ST_ARMED` or `ST_MUTED` → `ST_IDLE`, when the gate becomes disabled.

Top module: `dual_noise_gate`

## Requirements
- R1: Each cycle with `s_valid` high is followed one clock later by a cycle with `m_valid` high, and by no other. When that channel's `mute_o` bit is low in that output cycle, `m_a`/`m_b` equal the input samples exactly.
- R2: A sample is loud when its absolute value is greater than or equal to the channel threshold. The most negative code, -8388608, has magnitude 8388608.
- R3: With boost off, threshold codes 0 to 5 give the linear magnitudes 5293, 4204, 2653, 1878, 1330 and 666 (about -64, -66, -70, -73, -76 and -82 dB of full scale). The otherwise unused codes 6 and 7 also give 666.
- R4: With boost on, threshold codes 0 to 7 give 167378, 132951, 83886, 59387, 42043, 21071, 10561 and 5293 (about -34 to -64 dB).
- R5: An enabled channel that receives no loud sample mutes on the N-th `tick` after it was armed or last saw a loud sample. N is 50, 100, 150 or 200 for delay codes 0, 1, 2 and 3. A loud sample in the same cycle as a tick restarts the count.
- R6: A loud valid sample on a muted channel clears its `mute_o` bit at the output edge of that sample, and the sample appears unchanged on the output.
- R7: While a channel's `mute_o` bit is high, every valid output sample on that channel is zero.
- R8: A `mute_o` bit only rises on a clock edge where `tick` was high.
- R9: The two channels gate independently. Bit 0 of `mute_o` belongs to channel A and bit 1 to channel B, and a loud sample on one channel never changes the other channel's mute or count.
- R10: Address 0 holds: bit 0 enable A, bit 1 enable B, bit 2 gang mode, bit 3 gang enable. With gang mode set, both channels follow the gang enable and the per-channel enables have no effect.
- R11: Address 1 holds: bits 2:0 threshold code, bit 3 boost, bits 5:4 delay code. A write that disables a channel clears that channel's mute within two clocks. Re-enabling the channel starts a full new count.
- R12: After reset all control fields are zero (both gates off), `mute_o` is 0 and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 1 | Control address (0 enables, 1 level/delay) |
| cfg_wdata | input | 8 | Control write data |
| tick | input | 1 | Time-base clock enable, one pulse per ms |
| s_valid | input | 1 | Input sample strobe |
| s_a | input | 24 | Channel A input sample, two's complement |
| s_b | input | 24 | Channel B input sample, two's complement |
| m_valid | output | 1 | Output sample strobe |
| m_a | output | 24 | Channel A gated sample |
| m_b | output | 24 | Channel B gated sample |
| mute_o | output | 2 | Mute flags, bit 0 = A, bit 1 = B |

## Verification
Each gated sample and its `mute_o` bit appear at the first clock edge after the input strobe. A mute caused by a tick is visible at the edge that samples that tick. A control write takes effect one edge after the strobe, and its effect on the mute flag shows one edge after that. The bench drives every input at a falling edge and reads the outputs at the next falling edge, or after the second edge for control writes. Every check therefore lands half a cycle after the register that produces the result has updated.

// File: rtl/ng_pkg.sv
package ng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MUTED = 2'd2
    } gate_state_t;

    typedef struct packed {
        logic [1:0] chan_en;
        logic       gang_mode;
        logic       gang_en;
        logic       boost;
        logic [2:0] thr_code;
        logic [1:0] dly_code;
    } gate_cfg_t;

    // Linear magnitudes for a 24-bit full scale (2^23)
    function automatic logic [23:0] thr_lookup(input logic boost, input logic [2:0] code);
        logic [23:0] v;
        if (boost) begin
            unique case (code)
                3'd0: v = 24'd167378;
                3'd1: v = 24'd132951;
                3'd2: v = 24'd83886;
                3'd3: v = 24'd59387;
                3'd4: v = 24'd42043;
                3'd5: v = 24'd21071;
                3'd6: v = 24'd10561;
                default: v = 24'd5293;
            endcase
        end else begin
            unique case (code)
                3'd0: v = 24'd5293;
                3'd1: v = 24'd4204;
                3'd2: v = 24'd2653;
                3'd3: v = 24'd1878;
                3'd4: v = 24'd1330;
                default: v = 24'd666;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/ng_cfg_regs.sv
module ng_cfg_regs
    import ng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    output gate_cfg_t  cfg,
    output logic [1:0] en_eff
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_we) begin
            if (!cfg_addr) begin
                cfg.chan_en   <= cfg_wdata[1:0];
                cfg.gang_mode <= cfg_wdata[2];
                cfg.gang_en   <= cfg_wdata[3];
            end else begin
                cfg.thr_code  <= cfg_wdata[2:0];
                cfg.boost     <= cfg_wdata[3];
                cfg.dly_code  <= cfg_wdata[5:4];
            end
        end
    end

    always_comb begin
        if (cfg.gang_mode) en_eff = {2{cfg.gang_en}};
        else               en_eff = cfg.chan_en;
    end

endmodule

// File: rtl/ng_level_det.sv
module ng_level_det
    import ng_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] sample,
    input  logic              boost,
    input  logic [2:0]        thr_code,
    output logic              loud
);

    localparam int SHIFT = DATA_W - 24;

    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] thr;
    logic [23:0]       thr24;

    always_comb begin
        thr24 = thr_lookup(boost, thr_code);
        mag   = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
    end

    generate
        if (SHIFT > 0) begin : g_wide
            assign thr = {thr24, {SHIFT{1'b0}}};
        end else begin : g_exact
            assign thr = thr24[23 -: DATA_W];
        end
    endgenerate

    assign loud = (mag >= thr);

endmodule

// File: rtl/ng_gate_fsm.sv
module ng_gate_fsm
    import ng_pkg::*;
#(
    parameter int STEP_TICKS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       hit,
    input  logic       tick,
    input  logic [1:0] dly_code,
    output logic       mute,
    output logic       mute_next
);

    localparam int MAX_TICKS = 4 * STEP_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    gate_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'((32'(dly_code) + 32'd1) * 32'(STEP_TICKS));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (en) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (hit) begin
                    cnt_n = '0;
                end else if (tick) begin
                    if (cnt >= limit - 1'b1) begin
                        state_n = ST_MUTED;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_MUTED: begin
                cnt_n = '0;
                if (!en)      state_n = ST_IDLE;
                else if (hit) state_n = ST_ARMED;
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        mute      = (state == ST_MUTED);
        mute_next = (state_n == ST_MUTED);
    end

endmodule

// File: rtl/dual_noise_gate.sv
module dual_noise_gate
    import ng_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int STEP_TICKS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              tick,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_a,
    input  logic [DATA_W-1:0] s_b,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_a,
    output logic [DATA_W-1:0] m_b,
    output logic [1:0]        mute_o
);

    localparam int NCH = 2;

    gate_cfg_t                     cfg;
    logic [NCH-1:0]                en_eff;
    logic [NCH-1:0][DATA_W-1:0]    s_arr;
    logic [NCH-1:0][DATA_W-1:0]    m_arr;
    logic [NCH-1:0]                loud;
    logic [NCH-1:0]                mute_nx;

    assign s_arr[0] = s_a;
    assign s_arr[1] = s_b;
    assign m_a      = m_arr[0];
    assign m_b      = m_arr[1];

    ng_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .en_eff    (en_eff)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            ng_level_det #(.DATA_W(DATA_W)) u_det (
                .sample   (s_arr[ch]),
                .boost    (cfg.boost),
                .thr_code (cfg.thr_code),
                .loud     (loud[ch])
            );

            ng_gate_fsm #(.STEP_TICKS(STEP_TICKS)) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (en_eff[ch]),
                .hit       (s_valid && loud[ch]),
                .tick      (tick),
                .dly_code  (cfg.dly_code),
                .mute      (mute_o[ch]),
                .mute_next (mute_nx[ch])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       m_arr[ch] <= '0;
                else if (s_valid) m_arr[ch] <= mute_nx[ch] ? '0 : s_arr[ch];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_valid <= 1'b0;
        else        m_valid <= s_valid;
    end

endmodule

// File: rtl/ng_gate_checker.sv
module ng_gate_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              s_valid,
    input logic [DATA_W-1:0] s_a,
    input logic [DATA_W-1:0] s_b,
    input logic              m_valid,
    input logic [DATA_W-1:0] m_a,
    input logic [DATA_W-1:0] m_b,
    input logic [1:0]        mute_o,
    input logic [1:0]        en_eff
);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> m_valid);
    p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> !m_valid);
    p_pass_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !mute_o[0]) |-> (m_a == $past(s_a)));
    p_pass_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !mute_o[1]) |-> (m_b == $past(s_b)));
    p_zero_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && mute_o[0]) |-> (m_a == '0));
    p_zero_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && mute_o[1]) |-> (m_b == '0));
    p_attack_tick_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_o[0]) |-> $past(tick));
    p_attack_tick_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_o[1]) |-> $past(tick));
    p_off_clear_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff[0] |=> !mute_o[0]);
    p_off_clear_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff[1] |=> !mute_o[1]);

endmodule

bind dual_noise_gate ng_gate_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .s_valid (s_valid),
    .s_a     (s_a),
    .s_b     (s_b),
    .m_valid (m_valid),
    .m_a     (m_a),
    .m_b     (m_b),
    .mute_o  (mute_o),
    .en_eff  (en_eff)
);

// File: tb/test_dual_noise_gate.sv
module test_dual_noise_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        tick = 1'b0;
    logic        s_valid = 1'b0;
    logic [23:0] s_a = '0;
    logic [23:0] s_b = '0;
    logic        m_valid;
    logic [23:0] m_a;
    logic [23:0] m_b;
    logic [1:0]  mute_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam int QUIET = 100;
    localparam int LOUD  = 1000000;

    always #5 clk = ~clk;

    dual_noise_gate i_dual_noise_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tick(tick), .s_valid(s_valid),
        .s_a(s_a), .s_b(s_b), .m_valid(m_valid), .m_a(m_a), .m_b(m_b),
        .mute_o(mute_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input int a, input int b);
        @(negedge clk);
        s_valid = 1'b1; s_a = 24'(a); s_b = 24'(b);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic int exp_thr(input bit boost, input int code);
        int lo[8] = '{5293, 4204, 2653, 1878, 1330, 666, 666, 666};
        int hi[8] = '{167378, 132951, 83886, 59387, 42043, 21071, 10561, 5293};
        return boost ? hi[code] : lo[code];
    endfunction

    task automatic t_reset;
        chk("R12 mute after reset", int'(mute_o), 0);
        chk("R12 m_valid after reset", int'(m_valid), 0);
        send(QUIET, -QUIET);
        chk("R12 gate off passes A", int'($signed(m_a)), QUIET);
        chk("R1 m_valid follows", int'(m_valid), 1);
        @(negedge clk);
        chk("R1 m_valid single cycle", int'(m_valid), 0);
        ticks(250);
        chk("R12 no mute when disabled", int'(mute_o), 0);
    endtask

    task automatic t_delay(input int dly);
        int n = 50 * (dly + 1);
        wr(1'b1, 8'(dly << 4));
        wr(1'b0, 8'h01);
        send(LOUD, LOUD);
        ticks(n - 1);
        chk($sformatf("R5 no mute at %0d-1 ticks", n), int'(mute_o[0]), 0);
        ticks(1);
        chk($sformatf("R5 mute at %0d ticks", n), int'(mute_o[0]), 1);
        chk("R9 B stays unmuted", int'(mute_o[1]), 0);
        send(QUIET, QUIET);
        chk("R7 muted A zero", int'(m_a), 0);
        chk("R9 B passes", int'($signed(m_b)), QUIET);
        send(LOUD, 0);
        chk("R6 release mute", int'(mute_o[0]), 0);
        chk("R6 release sample passes", int'($signed(m_a)), LOUD);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_restart;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h01);
        ticks(30);
        send(-LOUD, 0);
        ticks(30);
        chk("R5 restart keeps open", int'(mute_o[0]), 0);
        @(negedge clk); tick = 1'b1; s_valid = 1'b1; s_a = 24'(LOUD);
        @(negedge clk); tick = 1'b0; s_valid = 1'b0;
        ticks(49);
        chk("R5 loud with tick restarts", int'(mute_o[0]), 0);
        ticks(1);
        chk("R5 mute after restart", int'(mute_o[0]), 1);
        wr(1'b0, 8'h00);
        chk("R11 disable clears mute", int'(mute_o[0]), 0);
        wr(1'b0, 8'h01);
        ticks(49);
        chk("R11 re-enable full count", int'(mute_o[0]), 0);
        ticks(1);
        chk("R11 re-enable mutes", int'(mute_o[0]), 1);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_thr(input bit boost, input int code);
        int thr = exp_thr(boost, code);
        string tg = boost ? "R4" : "R3";
        wr(1'b1, {4'b0000, boost, 3'(code)});
        wr(1'b0, 8'h02);
        send(0, LOUD);
        ticks(50);
        chk($sformatf("%s code %0d muted", tg, code), int'(mute_o[1]), 1);
        send(0, thr - 1);
        chk($sformatf("%s code %0d below thr holds", tg, code), int'(mute_o[1]), 1);
        chk("R7 below thr zero", int'(m_b), 0);
        send(0, -thr);
        chk($sformatf("R2 %s code %0d at -thr releases", tg, code), int'(mute_o[1]), 0);
        chk("R6 -thr passes", int'($signed(m_b)), -thr);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_minneg;
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h01);
        send(LOUD, 0);
        ticks(50);
        send(-8388608, 0);
        chk("R2 most negative is loud", int'(mute_o[0]), 0);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_gang;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h07);
        send(LOUD, LOUD);
        ticks(60);
        chk("R10 gang off ignores chan enables", int'(mute_o), 0);
        wr(1'b0, 8'h0C);
        send(LOUD, LOUD);
        ticks(50);
        chk("R10 gang on mutes both", int'(mute_o), 3);
        send(QUIET, LOUD);
        chk("R9 B release leaves A", int'(mute_o), 1);
        wr(1'b0, 8'h00);
        chk("R11 disable clears all", int'(mute_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int d = 0; d < 4; d++) t_delay(d);
        t_restart();
        for (int c = 0; c < 8; c++) t_thr(1'b0, c);
        for (int c = 0; c < 8; c++) t_thr(1'b1, c);
        t_minneg();
        t_gang();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule